// File: doc/BRIEF.md
# Concatenable Four-Channel PWM Generator

The block produces four pulse-width modulated outputs from one shared clock prescaler. Every channel owns an 8-bit period value, an 8-bit duty value and an enable bit, all written through a simple register port that can also be read back. While a channel runs, its counter advances once per prescaler tick. The output is high for the first `duty` ticks of each period and low for the remaining ticks.

Two neighbouring channels can be joined into a single 16-bit channel. In that case the upper channel's period and duty bytes supply the high byte, and the lower channel's bytes supply the low byte. The joined waveform appears on the lower output, and only the lower enable bit starts or stops it. The prescaler is held at zero whenever every enable bit is clear. Enables are synchronised to the prescaler tick, so the first period after an enable can be irregular when other channels are already running. New period and duty values take effect only at a period boundary.

Top module: `pwm_concat_gen`

## Requirements
- R1: After reset every register reads 0 and all four outputs are low.
- R2: Register map on the 6-bit address: 0x00 holds the enables (bit i enables channel i), 0x01 holds the join bits (bit 0 joins channels 0/1, bit 1 joins channels 2/3), 0x12+i is the period of channel i and 0x18+i is its duty. Every other address reads 0. Reads are combinational from the address.
- R3: The shared prescaler issues one tick every PRE_DIV clock cycles (default 4), and a running channel counter advances by one on each tick.
- R4: When an enable is written at clock edge E while all channels are idle, that output stays low until edge E+PRE_DIV and goes high after that edge if its duty is non-zero.
- R5: A running channel is high for `duty` ticks and low for `period - duty` ticks, and repeats every `period` ticks.
- R6: A duty greater than or equal to the period, or a period of zero, holds the output constantly high while the channel is enabled.
- R7: Period and duty writes made while a channel runs are taken up only at the start of the next period. Values written while a channel is disabled are used from its first period.
- R8: Clearing an enable drives that output low from the same edge. The channel counter returns to zero, so a later enable starts a fresh period.
- R9: With all enables clear, the prescaler is held at zero. After any idle gap, a new enable therefore sees the full PRE_DIV start delay of R4.
- R10: With a pair joined, the 16-bit period `{period[hi], period[lo]}` and duty `{duty[hi], duty[lo]}` drive the lower channel's output, started and stopped by the lower enable bit alone.
- R11: With a pair joined, the upper output is held low and the upper enable bit has no effect, even when it is the only bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pwm_out | output | 4 | Channel outputs |

## Verification
The hardest situation to reach is a duty value rewritten in the middle of a running period. The new value must appear exactly at the next wrap, and never at the write itself. The stimulus queues the whole expected waveform first. It then issues the write on a chosen edge, which lies six cycles into the second period, and predicts the period index at which the new duty takes over. The 16-bit joined mode is driven with a period above 255 while the upper enable is also set. This shows that the high byte is used and that the upper output stays low. A separate case sets only the upper enable of a joined pair.

// File: rtl/pwm_cg_pkg.sv
package pwm_cg_pkg;
   localparam int unsigned ENA_ADR  = 'h00;
   localparam int unsigned JOIN_ADR = 'h01;
   localparam int unsigned PER_ADR  = 'h12;
   localparam int unsigned DTY_ADR  = 'h18;

   function automatic int unsigned cnt_w(input int unsigned div);
      return (div > 1) ? $clog2(div) : 1;
   endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int unsigned DIV = 4,
   parameter int unsigned PW  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   output logic          tick,
   output logic [PW-1:0] cnt
);
   generate
      if (DIV > 1) begin : g_count
         always_ff @(posedge clk) begin
            if (!rst_n || !run)              cnt <= '0;
            else if (cnt == PW'(DIV - 1))    cnt <= '0;
            else                             cnt <= cnt + PW'(1);
         end
         assign tick = run && (cnt == PW'(DIV - 1));
      end else begin : g_pass
         assign cnt  = '0;
         assign tick = run;
      end
   endgenerate
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         en,
   input  logic [W-1:0] per_in,
   input  logic [W-1:0] dty_in,
   output logic         out
);
   logic         run;
   logic [W-1:0] cnt, act_per, act_dty;
   logic         at_end;

   assign at_end = (act_per == '0) || (cnt >= act_per - W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run     <= 1'b0;
         cnt     <= '0;
         act_per <= '0;
         act_dty <= '0;
      end else if (!en) begin
         run     <= 1'b0;
         cnt     <= '0;
         act_per <= per_in;
         act_dty <= dty_in;
      end else if (tick) begin
         if (!run || at_end) begin
            run     <= 1'b1;
            cnt     <= '0;
            act_per <= per_in;
            act_dty <= dty_in;
         end else begin
            cnt <= cnt + W'(1);
         end
      end
   end

   assign out = en && run && ((cnt < act_dty) || (act_dty >= act_per));
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [1:0]   en,
   input  logic         join_on,
   input  logic [W-1:0] per_lo,
   input  logic [W-1:0] per_hi,
   input  logic [W-1:0] dty_lo,
   input  logic [W-1:0] dty_hi,
   output logic [1:0]   out
);
   logic lo_out, hi_out, wide_out;

   pwm_chan #(.W(W)) u_lo (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en[0] && !join_on),
      .per_in(per_lo), .dty_in(dty_lo), .out(lo_out));

   pwm_chan #(.W(W)) u_hi (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en[1] && !join_on),
      .per_in(per_hi), .dty_in(dty_hi), .out(hi_out));

   pwm_chan #(.W(2*W)) u_wide (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en[0] && join_on),
      .per_in({per_hi, per_lo}), .dty_in({dty_hi, dty_lo}), .out(wide_out));

   assign out = join_on ? {1'b0, wide_out} : {hi_out, lo_out};
endmodule

// File: rtl/pwm_concat_gen.sv
module pwm_concat_gen
   import pwm_cg_pkg::*;
#(
   parameter int unsigned NCH     = 4,
   parameter int unsigned DW      = 8,
   parameter int unsigned AW      = 6,
   parameter int unsigned PRE_DIV = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic [NCH-1:0] pwm_out
);
   localparam int unsigned NPAIR = NCH / 2;
   localparam int unsigned PRE_W = cnt_w(PRE_DIV);

   if (NCH % 2 != 0)                 begin : g_bad_nch  $error("NCH must be even");              end
   if (DW < NCH)                     begin : g_bad_dw   $error("DW must hold one bit per channel"); end
   if (PRE_DIV < 1)                  begin : g_bad_div  $error("PRE_DIV must be at least 1");    end
   if (DTY_ADR < PER_ADR + NCH)      begin : g_bad_map  $error("period and duty ranges overlap"); end
   if ((1 << AW) < DTY_ADR + NCH)    begin : g_bad_aw   $error("AW too narrow for the map");     end

   logic [NCH-1:0]   en_q;
   logic [NPAIR-1:0] join_q;
   logic [DW-1:0]    per_q [NCH];
   logic [DW-1:0]    dty_q [NCH];
   logic             tick;
   logic [PRE_W-1:0] pre_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         join_q <= '0;
         for (int i = 0; i < NCH; i++) begin
            per_q[i] <= '0;
            dty_q[i] <= '0;
         end
      end else if (wr_en) begin
         if (addr == AW'(ENA_ADR))  en_q   <= wdata[NCH-1:0];
         if (addr == AW'(JOIN_ADR)) join_q <= wdata[NPAIR-1:0];
         for (int i = 0; i < NCH; i++) begin
            if (addr == AW'(PER_ADR + i)) per_q[i] <= wdata;
            if (addr == AW'(DTY_ADR + i)) dty_q[i] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == AW'(ENA_ADR))  rdata[NCH-1:0]   = en_q;
      if (addr == AW'(JOIN_ADR)) rdata[NPAIR-1:0] = join_q;
      for (int i = 0; i < NCH; i++) begin
         if (addr == AW'(PER_ADR + i)) rdata = per_q[i];
         if (addr == AW'(DTY_ADR + i)) rdata = dty_q[i];
      end
   end

   pwm_prescaler #(.DIV(PRE_DIV), .PW(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(|en_q), .tick(tick), .cnt(pre_cnt));

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      pwm_pair #(.W(DW)) u_pair (
         .clk(clk), .rst_n(rst_n), .tick(tick),
         .en(en_q[2*p+1 -: 2]), .join_on(join_q[p]),
         .per_lo(per_q[2*p]), .per_hi(per_q[2*p+1]),
         .dty_lo(dty_q[2*p]), .dty_hi(dty_q[2*p+1]),
         .out(pwm_out[2*p+1 -: 2]));
   end
endmodule

// File: rtl/pwm_cg_chk.sv
module pwm_cg_chk
   import pwm_cg_pkg::*;
#(
   parameter int unsigned NCH     = 4,
   parameter int unsigned DW      = 8,
   parameter int unsigned AW      = 6,
   parameter int unsigned PRE_DIV = 4,
   parameter int unsigned PRE_W   = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [AW-1:0]    addr,
   input logic [DW-1:0]    wdata,
   input logic [NCH-1:0]   en_q,
   input logic [NCH/2-1:0] join_q,
   input logic             tick,
   input logic [PRE_W-1:0] pre_cnt,
   input logic [NCH-1:0]   pwm_out
);
   // R2
   ena_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(ENA_ADR)) |=> (en_q == $past(wdata[NCH-1:0])));

   // R9
   idle_presc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |=> (pre_cnt == '0));

   // R8
   idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> (pwm_out == '0));

   if (PRE_DIV > 1) begin : g_gap
      // R3
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end

   for (genvar p = 0; p < NCH/2; p++) begin : g_p
      // R11
      hi_joined_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         join_q[p] |-> !pwm_out[2*p+1]);
      // R8
      lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !en_q[2*p] |-> !pwm_out[2*p]);
      // R8
      hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !en_q[2*p+1] |-> !pwm_out[2*p+1]);
   end
endmodule

bind pwm_concat_gen pwm_cg_chk #(
   .NCH(NCH), .DW(DW), .AW(AW), .PRE_DIV(PRE_DIV), .PRE_W(PRE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .en_q(en_q), .join_q(join_q), .tick(tick), .pre_cnt(pre_cnt),
   .pwm_out(pwm_out));

// File: tb/sim_pwm_concat_gen.sv
module sim_pwm_concat_gen;
   localparam int DIV = 4;
   localparam int BIG = 1 << 30;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [5:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [3:0] pwm_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [3:0] v;
      string      tag;
   } exp_t;
   exp_t q[$];

   int c_per[4], c_d1[4], c_d2[4], c_sw[4];
   bit c_on[4];

   always #10 clk = ~clk;

   pwm_concat_gen u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

   // monitor: one expected vector per cycle, sampled at the falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t it;
         it = q.pop_front();
         n_cmp++;
         if (pwm_out !== it.v) begin
            n_bad++;
            $display("FAIL %s: pwm_out=%b expected %b at %0t", it.tag, pwm_out, it.v, $time);
         end
      end
   end

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [5:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      addr = a;
      #2;
      n_cmp++;
      if (rdata !== e) begin
         n_bad++;
         $display("FAIL %s: rdata[0x%0h]=0x%0h expected 0x%0h", tag, a, rdata, e);
      end
   endtask

   function automatic bit wave(int k, int per, int d1, int d2, int sw);
      int j, m, d, c;
      if (k < DIV) return 1'b0;
      j = (k - DIV) / DIV;
      if (per == 0) return 1'b1;
      m = j / per;
      d = (DIV + m * per * DIV > sw) ? d2 : d1;
      c = j % per;
      return (c < d) || (d >= per);
   endfunction

   // driver: push expected outputs for n cycles after the enable edge
   task automatic push_run(input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         exp_t it;
         for (int i = 0; i < 4; i++)
            it.v[i] = c_on[i] ? wave(k, c_per[i], c_d1[i], c_d2[i], c_sw[i]) : 1'b0;
         it.tag = tag;
         q.push_back(it);
      end
   endtask

   task automatic push_zero(input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         exp_t it;
         it.v = '0; it.tag = tag;
         q.push_back(it);
      end
   endtask

   task automatic drain();
      wait (q.size() == 0);
   endtask

   task automatic cfg(input int i, input bit on, input int per, input int d);
      c_on[i] = on; c_per[i] = per; c_d1[i] = d; c_d2[i] = d; c_sw[i] = BIG;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) cfg(i, 1'b0, 0, 0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      rd_chk(6'h00, 8'h00, "R1");
      rd_chk(6'h01, 8'h00, "R1");
      rd_chk(6'h12, 8'h00, "R1");
      rd_chk(6'h1B, 8'h00, "R1");
      push_zero(4, "R1");
      drain();

      // R2: register map
      wr(6'h12, 8'd5); wr(6'h13, 8'd3); wr(6'h14, 8'd0); wr(6'h15, 8'd7);
      wr(6'h18, 8'd2); wr(6'h19, 8'd7); wr(6'h1A, 8'd4); wr(6'h1B, 8'd1);
      wr(6'h01, 8'h02);
      rd_chk(6'h12, 8'd5, "R2");
      rd_chk(6'h15, 8'd7, "R2");
      rd_chk(6'h19, 8'd7, "R2");
      rd_chk(6'h1A, 8'd4, "R2");
      rd_chk(6'h01, 8'h02, "R2");
      rd_chk(6'h10, 8'h00, "R2");
      wr(6'h01, 8'h00);
      rd_chk(6'h01, 8'h00, "R2");

      // R4 / R5 / R3: single channel from idle, period 5 duty 2
      cfg(0, 1'b1, 5, 2);
      wr(6'h00, 8'h01);
      push_run(60, "R5");
      drain();
      rd_chk(6'h00, 8'h01, "R2");

      // R8: disable drives low at once
      wr(6'h00, 8'h00);
      cfg(0, 1'b0, 0, 0);
      push_zero(10, "R8");
      drain();

      // R6 / R5: three channels together
      cfg(1, 1'b1, 3, 7);
      cfg(2, 1'b1, 0, 4);
      cfg(3, 1'b1, 7, 1);
      wr(6'h00, 8'h0E);
      push_run(80, "R6");
      drain();
      wr(6'h00, 8'h00);
      for (int i = 0; i < 4; i++) cfg(i, 1'b0, 0, 0);
      push_zero(6, "R8");
      drain();
      repeat (7) @(posedge clk);

      // R9 / R7: restart after idle gap, duty rewritten mid-run at edge +30
      cfg(0, 1'b1, 5, 2);
      c_d2[0] = 4; c_sw[0] = 30;
      wr(6'h00, 8'h01);
      push_run(80, "R7");
      repeat (29) @(posedge clk);
      wr(6'h18, 8'd4);
      drain();
      wr(6'h00, 8'h00);
      cfg(0, 1'b0, 0, 0);
      push_zero(5, "R8");
      drain();

      // R10 / R11: join pair 0, period 0x0103 duty 0x0102, both enables set
      wr(6'h12, 8'h03); wr(6'h13, 8'h01);
      wr(6'h18, 8'h02); wr(6'h19, 8'h01);
      wr(6'h01, 8'h01);
      cfg(0, 1'b1, 259, 258);
      cfg(1, 1'b0, 0, 0);
      wr(6'h00, 8'h03);
      push_run(1100, "R10");
      drain();
      wr(6'h00, 8'h00);
      cfg(0, 1'b0, 0, 0);
      push_zero(5, "R8");
      drain();

      // R11: pair 1 joined, only the upper enable set -> nothing runs
      wr(6'h01, 8'h02);
      wr(6'h00, 8'h08);
      push_zero(40, "R11");
      drain();
      wr(6'h00, 8'h00);
      wr(6'h01, 8'h00);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule